// File: doc/BRIEF.md
# Banked GPIO Register Controller

This block is a memory-mapped general-purpose I/O controller for up to 96 pins. The pins are split into three banks of 32. Each bank has three registers. The ownership register hands a pin either to GPIO control or to its native function. The direction register makes a pin an input or an output. The level register returns input values when read and sets the driven output values when written. A blink register applies only to the first bank. For an output pin whose level is 1, it makes the driven value toggle at a slow divided-clock rate.

Software reaches the registers over a simple 32-bit read/write bus with a byte address. Writes take effect on the clock edge that accepts them. Read data is registered. On the pin side, the block receives the pad input values and each pin's native-function output and output enable. It returns the final output value and output enable for every pin.

Three parameter masks state, pin by pin, whether a pin can be an input, whether it can be an output, and whether it can be placed under GPIO control at all. A write that asks for a capability the pin lacks does not stick. A readback therefore shows the mismatch.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: Pin n is bit (n mod 32) of bank (n div 32). The byte offsets are fixed as follows. Bank 0: ownership 0x00, direction 0x04, level 0x0C. Bank 1: ownership 0x30, direction 0x34, level 0x38. Bank 2: ownership 0x40, direction 0x44, level 0x48.
- R2: A synchronous active-low reset leaves the registers in this state:
  - every GPIO-capable implemented pin is owned by GPIO (bit 1);
  - every input-capable pin has direction 1 (input), and output-only pins have direction 0;
  - all output levels and blink bits are 0;
  - the read data register is 0.
- R3: An ownership bit of 1 gives the pin to GPIO control, and 0 leaves it on its native function. A pin with ownership 0 has pin_out and pin_oe equal to its alt_out and alt_oe inputs. Pins without GPIO capability always read 0 in the ownership register.
- R4: A direction bit of 1 makes the pin an input and 0 makes it an output. For a GPIO-owned pin, pin_oe is the inverse of its direction bit.
- R5: Direction writes that ask for an unsupported direction leave the stored bit unchanged. Writing 1 to an output-only pin leaves it at 0. Writing 0 to an input-only pin leaves it at 1.
- R6: A write to a level register sets the driven value of the pins in that bank. For an output pin, a level read returns the written value.
- R7: For an input pin, a level read returns the pad value after a two-flop synchroniser. A pad change presented just before a read request is not yet visible in that read. It becomes visible once two further edges have passed.
- R8: The blink register sits at byte offset 0x18, and bit i covers pin i, for pins 0 to 31 only. A GPIO output with level 1 and blink 1 toggles, high for BLINK_HALF cycles and then low for BLINK_HALF cycles. With level 0 the pin stays low. Clearing blink returns the pin to a steady level.
- R9: Bits for pins at or above NUM_PINS read as 0 in every register, and writes to them have no effect.
- R10: A read of any offset not listed in R1 or R8 returns 0. A write to such an offset changes no register. Misaligned offsets count as unmapped.
- R11: Read data is captured on the edge where bus_rd is 1 and is visible in the following cycle. While bus_rd is 0, bus_rdata holds its value, even across writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe; data appears the next cycle |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | NUM_PINS | Pad input values, asynchronous |
| alt_out | input | NUM_PINS | Native-function output value per pin |
| alt_oe | input | NUM_PINS | Native-function output enable per pin |
| pin_out | output | NUM_PINS | Final output value per pin |
| pin_oe | output | NUM_PINS | Final output enable per pin |

## Verification
The embedded properties rest on three assumptions:
- every pin has at least one direction capability in the masks;
- reset is held low from time zero for at least one edge;
- bus_wr and bus_rd are single-cycle strobes whose address is stable at the clock edge.

The stimulus keeps within these assumptions. It uses capability masks in which each restricted pin keeps one direction. It changes pads and bus signals only at falling edges. It waits three cycles after a pad change before comparing an input level against the model; the one exception is the directed synchroniser case, which deliberately reads at once.

// File: rtl/gpio_bank_pkg.sv
// Shared constants and helpers for the banked GPIO controller.
// Assumes three banks of 32 pins and an 8-bit byte offset space.
package gpio_bank_pkg;

    localparam int BANK_W    = 32;
    localparam int MAX_BANKS = 3;
    localparam int MAX_PINS  = BANK_W * MAX_BANKS;

    localparam logic [7:0] BLINK_OFF = 8'h18;

    // Byte offset of the ownership register of a bank.
    function automatic logic [7:0] own_off(input int bank);
        case (bank)
            0:       return 8'h00;
            1:       return 8'h30;
            default: return 8'h40;
        endcase
    endfunction

    // Byte offset of the direction register of a bank.
    function automatic logic [7:0] dir_off(input int bank);
        case (bank)
            0:       return 8'h04;
            1:       return 8'h34;
            default: return 8'h44;
        endcase
    endfunction

    // Byte offset of the level register of a bank.
    function automatic logic [7:0] lvl_off(input int bank);
        case (bank)
            0:       return 8'h0C;
            1:       return 8'h38;
            default: return 8'h48;
        endcase
    endfunction

    // Mask of the implemented pins inside one bank.
    function automatic logic [BANK_W-1:0] impl_mask(input int bank, input int npins);
        logic [BANK_W-1:0] m;
        for (int i = 0; i < BANK_W; i++) begin
            m[i] = ((bank * BANK_W + i) < npins);
        end
        return m;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
// Two-flop synchroniser for the asynchronous pad inputs.
// Assumes each bit is independent; no multi-bit coherence is given.
module gpio_in_sync #(
    parameter int W = 76
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage1;

    // Shift the pad values through two register stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end

endmodule

// File: rtl/gpio_blink_div.sv
// Free-running divider that produces the blink phase.
// The phase holds for HALF cycles and then inverts; HALF must be 1 or more.
module gpio_blink_div #(
    parameter int HALF = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic phase
);

    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt;

    // Count cycles and invert the phase at the end of each half period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            phase <= 1'b1;
        end else if (cnt == LAST) begin
            cnt   <= '0;
            phase <= ~phase;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R8
    blink_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0) |-> $stable(phase));

    // R8
    blink_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

endmodule

// File: rtl/gpio_reg_bank.sv
// One bank of 32 pins: ownership, direction, level and an optional blink register.
// Assumes the write strobes are one-hot and that every pin has at least one
// direction capability. Read selects come from the same address decode.
module gpio_reg_bank
    import gpio_bank_pkg::*;
#(
    parameter int                BANK_IDX  = 0,
    parameter int                NUM_PINS  = 76,
    parameter bit                HAS_BLINK = 1'b0,
    parameter logic [BANK_W-1:0] IN_CAP    = '1,
    parameter logic [BANK_W-1:0] OUT_CAP   = '1,
    parameter logic [BANK_W-1:0] OWN_CAP   = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_own,
    input  logic              wr_dir,
    input  logic              wr_lvl,
    input  logic              wr_blink,
    input  logic              rd_own,
    input  logic              rd_dir,
    input  logic              rd_lvl,
    input  logic              rd_blink,
    input  logic [BANK_W-1:0] wdata,
    input  logic [BANK_W-1:0] sync_in,
    input  logic              blink_phase,
    output logic [BANK_W-1:0] own_q,
    output logic [BANK_W-1:0] dir_q,
    output logic [BANK_W-1:0] drive,
    output logic [BANK_W-1:0] rd_data
);

    localparam logic [BANK_W-1:0] IMPL    = impl_mask(BANK_IDX, NUM_PINS);
    localparam logic [BANK_W-1:0] OWN_RST = OWN_CAP & IMPL;
    localparam logic [BANK_W-1:0] DIR_RST = IN_CAP & IMPL;

    logic [BANK_W-1:0] lvl_q;
    logic [BANK_W-1:0] blink_q;
    logic [BANK_W-1:0] dir_next;
    logic [BANK_W-1:0] lvl_rd;

    // Accept a direction bit only when the pin supports that direction.
    always_comb begin
        for (int i = 0; i < BANK_W; i++) begin
            dir_next[i] = (IMPL[i] && (wdata[i] ? IN_CAP[i] : OUT_CAP[i])) ? wdata[i] : dir_q[i];
        end
    end

    // Ownership, direction and level storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own_q <= OWN_RST;
            dir_q <= DIR_RST;
            lvl_q <= '0;
        end else begin
            if (wr_own) own_q <= wdata & OWN_CAP & IMPL;
            if (wr_dir) dir_q <= dir_next;
            if (wr_lvl) lvl_q <= wdata & IMPL;
        end
    end

    if (HAS_BLINK) begin : g_blink
        // Blink enable storage for the bank that owns it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                blink_q <= '0;
            end else if (wr_blink) begin
                blink_q <= wdata & IMPL;
            end
        end
    end else begin : g_no_blink
        logic unused_wr_blink;
        assign unused_wr_blink = wr_blink;
        assign blink_q = '0;
    end

    // Level view: synchronised pad for inputs, stored level for outputs.
    assign lvl_rd = IMPL & ((dir_q & sync_in) | (~dir_q & lvl_q));

    // Driven value: blinking outputs drop low during the off phase.
    assign drive = lvl_q & ~(blink_q & ~dir_q & {BANK_W{~blink_phase}});

    // Bank read data from the selected register.
    always_comb begin
        rd_data = ({BANK_W{rd_own}}   & own_q)
                | ({BANK_W{rd_dir}}   & dir_q)
                | ({BANK_W{rd_lvl}}   & lvl_rd)
                | ({BANK_W{rd_blink}} & blink_q);
    end

    // R5
    dir_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((dir_q & ~IN_CAP) == '0) && ((~dir_q & ~OUT_CAP & IMPL) == '0));

    // R9
    unimpl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((own_q | dir_q | lvl_q | blink_q) & ~IMPL) == '0);

    // R10
    reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_own || wr_dir || wr_lvl || wr_blink) |=> $stable({own_q, dir_q, lvl_q, blink_q}));

endmodule

// File: rtl/gpio_bank_ctrl.sv
// Banked GPIO controller top: address decode, three register banks, the
// input synchroniser, the blink divider and the per-pin output multiplexer.
// Assumes NUM_PINS is at most 96 and that bus strobes last one cycle.
module gpio_bank_ctrl
    import gpio_bank_pkg::*;
#(
    parameter int                  NUM_PINS   = 76,
    parameter int                  ADDR_W     = 8,
    parameter int                  BLINK_HALF = 25_000_000,
    parameter logic [MAX_PINS-1:0] IN_CAP     = ~96'h60,
    parameter logic [MAX_PINS-1:0] OUT_CAP    = ~96'h300,
    parameter logic [MAX_PINS-1:0] OWN_CAP    = ~96'h100000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [31:0]         bus_wdata,
    input  logic                bus_rd,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic [NUM_PINS-1:0] alt_out,
    input  logic [NUM_PINS-1:0] alt_oe,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe
);

    logic [NUM_PINS-1:0]  pin_sync;
    logic [MAX_PINS-1:0]  sync_all;
    logic                 blink_phase;
    logic [MAX_BANKS-1:0] hit_own, hit_dir, hit_lvl;
    logic                 hit_blink;
    logic                 hit_any;
    logic [BANK_W-1:0]    rd_v [MAX_BANKS];
    logic [BANK_W-1:0]    rd_mux;
    logic [MAX_PINS-1:0]  own_all, dir_all, drv_all;
    logic [NUM_PINS-1:0]  own_np, dir_np, drv_np;
    logic                 unused_tail;

    gpio_in_sync #(.W(NUM_PINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pin_sync)
    );

    gpio_blink_div #(.HALF(BLINK_HALF)) u_blink (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (blink_phase)
    );

    assign sync_all  = MAX_PINS'(pin_sync);
    assign hit_blink = (bus_addr == ADDR_W'(BLINK_OFF));

    for (genvar b = 0; b < MAX_BANKS; b++) begin : g_bank
        assign hit_own[b] = (bus_addr == ADDR_W'(own_off(b)));
        assign hit_dir[b] = (bus_addr == ADDR_W'(dir_off(b)));
        assign hit_lvl[b] = (bus_addr == ADDR_W'(lvl_off(b)));

        gpio_reg_bank #(
            .BANK_IDX  (b),
            .NUM_PINS  (NUM_PINS),
            .HAS_BLINK (b == 0),
            .IN_CAP    (IN_CAP[b*BANK_W +: BANK_W]),
            .OUT_CAP   (OUT_CAP[b*BANK_W +: BANK_W]),
            .OWN_CAP   (OWN_CAP[b*BANK_W +: BANK_W])
        ) u_bank (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_own      (bus_wr && hit_own[b]),
            .wr_dir      (bus_wr && hit_dir[b]),
            .wr_lvl      (bus_wr && hit_lvl[b]),
            .wr_blink    (bus_wr && hit_blink),
            .rd_own      (hit_own[b]),
            .rd_dir      (hit_dir[b]),
            .rd_lvl      (hit_lvl[b]),
            .rd_blink    (hit_blink),
            .wdata       (bus_wdata),
            .sync_in     (sync_all[b*BANK_W +: BANK_W]),
            .blink_phase (blink_phase),
            .own_q       (own_all[b*BANK_W +: BANK_W]),
            .dir_q       (dir_all[b*BANK_W +: BANK_W]),
            .drive       (drv_all[b*BANK_W +: BANK_W]),
            .rd_data     (rd_v[b])
        );
    end

    assign hit_any = (|hit_own) | (|hit_dir) | (|hit_lvl) | hit_blink;

    // Combine the bank read data; unmapped offsets leave it zero.
    always_comb begin
        rd_mux = '0;
        for (int b = 0; b < MAX_BANKS; b++) begin
            rd_mux = rd_mux | rd_v[b];
        end
    end

    // Register read data on a read strobe, hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_mux;
        end
    end

    assign own_np = own_all[NUM_PINS-1:0];
    assign dir_np = dir_all[NUM_PINS-1:0];
    assign drv_np = drv_all[NUM_PINS-1:0];
    assign unused_tail = ^{own_all, dir_all, drv_all};

    // Per-pin choice between GPIO control and the native function.
    assign pin_out = (own_np & drv_np) | (~own_np & alt_out);
    assign pin_oe  = (own_np & ~dir_np) | (~own_np & alt_oe);

    // R10
    unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !hit_any) |=> (bus_rdata == '0));

    // R11
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    // R3
    native_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((pin_oe ^ alt_oe) | (pin_out ^ alt_out)) & ~own_np) == '0);

endmodule

// File: tb/tb_gpio_bank_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_bank_ctrl;

    localparam int NP   = 76;
    localparam int HALF = 4;
    localparam logic [95:0] T_IN  = ~96'h60;
    localparam logic [95:0] T_OUT = ~96'h300;
    localparam logic [95:0] T_OWN = ~96'h100000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic          bus_rd = 1'b0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] alt_out = '0;
    logic [NP-1:0] alt_oe = '0;
    logic [NP-1:0] pin_out;
    logic [NP-1:0] pin_oe;

    always #2.5 clk = ~clk;

    gpio_bank_ctrl #(
        .NUM_PINS(NP), .ADDR_W(8), .BLINK_HALF(HALF),
        .IN_CAP(T_IN), .OUT_CAP(T_OUT), .OWN_CAP(T_OWN)
    ) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .alt_out(alt_out), .alt_oe(alt_oe),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    int checks = 0;
    int errors = 0;
    logic [95:0] m_own, m_dir, m_lvl, m_blink;
    logic [95:0] impl = (96'h1 << NP) - 96'h1;

    function automatic logic [7:0] t_own(int b);
        return (b == 0) ? 8'h00 : (b == 1) ? 8'h30 : 8'h40;
    endfunction
    function automatic logic [7:0] t_dir(int b);
        return (b == 0) ? 8'h04 : (b == 1) ? 8'h34 : 8'h44;
    endfunction
    function automatic logic [7:0] t_lvl(int b);
        return (b == 0) ? 8'h0C : (b == 1) ? 8'h38 : 8'h48;
    endfunction
    function automatic logic [7:0] addr_tab(int i);
        if (i < 3) return t_own(i);
        if (i < 6) return t_dir(i - 3);
        if (i < 9) return t_lvl(i - 6);
        return 8'h18;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk96(string req, logic [95:0] act, logic [95:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_own   = T_OWN & impl;
        m_dir   = T_IN & impl;
        m_lvl   = '0;
        m_blink = '0;
    endtask

    task automatic model_write(logic [7:0] a, logic [31:0] d);
        for (int b = 0; b < 3; b++) begin
            if (a == t_own(b)) m_own[b*32 +: 32] = d & T_OWN[b*32 +: 32] & impl[b*32 +: 32];
            if (a == t_dir(b)) begin
                for (int i = 0; i < 32; i++) begin
                    int n;
                    n = b * 32 + i;
                    if (impl[n] && (d[i] ? T_IN[n] : T_OUT[n])) m_dir[n] = d[i];
                end
            end
            if (a == t_lvl(b)) m_lvl[b*32 +: 32] = d & impl[b*32 +: 32];
        end
        if (a == 8'h18) m_blink[31:0] = d & impl[31:0];
    endtask

    function automatic logic [31:0] exp_read(logic [7:0] a);
        logic [95:0] lv;
        lv = impl & ((m_dir & 96'(pin_in)) | (~m_dir & m_lvl));
        for (int b = 0; b < 3; b++) begin
            if (a == t_own(b)) return m_own[b*32 +: 32];
            if (a == t_dir(b)) return m_dir[b*32 +: 32];
            if (a == t_lvl(b)) return lv[b*32 +: 32];
        end
        if (a == 8'h18) return m_blink[31:0];
        return 32'h0;
    endfunction

    task automatic bus_write(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        model_write(a, d);
    endtask

    task automatic bus_read(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic read_chk(string req, logic [7:0] a);
        logic [31:0] e, d;
        e = exp_read(a);
        bus_read(a, d);
        chk(req, d, e);
    endtask

    task automatic check_all(string req);
        for (int i = 0; i < 10; i++) read_chk(req, addr_tab(i));
    endtask

    task automatic check_pins(string req);
        logic [95:0] eoe, eo, msk;
        eoe = (m_own & ~m_dir) | (~m_own & 96'(alt_oe));
        eo  = (m_own & m_lvl) | (~m_own & 96'(alt_out));
        msk = m_own & ~m_dir & m_blink & m_lvl;
        chk96(req, 96'(pin_oe) & impl, eoe & impl);
        chk96(req, 96'(pin_out) & impl & ~msk, eo & impl & ~msk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R11: watchdog expired, got hang expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        int highs;
        void'($urandom(32'd2024));
        model_reset();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: reset state of read data, registers and pins
        chk("R2 rdata", bus_rdata, 32'h0);
        check_pins("R2 pins");
        check_all("R2 regs");
        read_chk("R3 no-cap ownership bit reads 0", 8'h00);

        // R9: upper bits of bank 2 beyond pin 75
        bus_write(8'h40, 32'hFFFF_FFFF);
        read_chk("R9 own bank2", 8'h40);
        bus_read(8'h40, d);
        chk("R9 own bank2 value", d, 32'h0000_0FFF);

        // R5: unsupported direction writes do not stick
        bus_write(8'h04, 32'h0);
        bus_read(8'h04, d);
        chk("R5 input-only stays 1", d, 32'h0000_0300);
        bus_write(8'h04, 32'hFFFF_FFFF);
        bus_read(8'h04, d);
        chk("R5 output-only stays 0", d, 32'hFFFF_FF9F);

        // R1 and R4: pin 50 is bit 18 of bank 1
        bus_write(8'h34, ~32'h0004_0000);
        bus_write(8'h38, 32'h0004_0000);
        @(negedge clk);
        chk("R1 pin50 out", {31'b0, pin_out[50]}, 32'h1);
        chk("R4 pin50 oe", {31'b0, pin_oe[50]}, 32'h1);
        chk("R4 pin49 input oe", {31'b0, pin_oe[49]}, 32'h0);

        // R6: pin 70 output in bank 2, level read returns written value
        bus_write(8'h44, ~32'h0000_0040);
        bus_write(8'h48, 32'h0000_0040);
        bus_read(8'h48, d);
        chk("R6 level readback", d & 32'h40, 32'h40);
        chk("R6 pin70 out", {31'b0, pin_out[70]}, 32'h1);

        // R7: pin 40 (bank1 bit 8) input through the synchroniser
        @(negedge clk);
        pin_in[40] = 1'b1; bus_addr = 8'h38; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        chk("R7 not yet visible", bus_rdata & 32'h100, 32'h0);
        repeat (2) @(negedge clk);
        bus_read(8'h38, d);
        chk("R7 visible after sync", d & 32'h100, 32'h100);

        // R8: blink on pin 3
        bus_write(8'h04, m_dir[31:0] & ~32'h8);
        bus_write(8'h0C, m_lvl[31:0] | 32'h8);
        bus_write(8'h18, 32'h8);
        read_chk("R8 blink readback", 8'h18);
        highs = 0;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            highs += int'(pin_out[3]);
        end
        chk("R8 blink duty", 32'(highs), 32'd8);
        bus_write(8'h0C, m_lvl[31:0] & ~32'h8);
        highs = 0;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            highs += int'(pin_out[3]);
        end
        chk("R8 level 0 stays low", 32'(highs), 32'd0);
        bus_write(8'h0C, m_lvl[31:0] | 32'h8);
        bus_write(8'h18, 32'h0);
        highs = 0;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            highs += int'(pin_out[3]);
        end
        chk("R8 cleared steady", 32'(highs), 32'd16);

        // R10: unmapped and misaligned offsets
        bus_write(8'h08, 32'hFFFF_FFFF);
        bus_write(8'h1C, 32'hFFFF_FFFF);
        bus_write(8'h3C, 32'hFFFF_FFFF);
        bus_write(8'h01, 32'h0);
        bus_write(8'h31, 32'h0);
        read_chk("R10 unmapped 08", 8'h08);
        read_chk("R10 unmapped 01", 8'h01);
        check_all("R10 state unchanged");

        // R11: read data holds while no read is requested
        bus_read(8'h30, d);
        bus_write(8'h30, ~d);
        repeat (3) @(negedge clk);
        chk("R11 hold", bus_rdata, d);

        // R3: bank 0 returned to native function
        alt_out = NP'({$urandom, $urandom, $urandom});
        alt_oe  = NP'({$urandom, $urandom, $urandom});
        bus_write(8'h00, 32'h0);
        @(negedge clk);
        chk("R3 native out", pin_out[31:0], alt_out[31:0]);
        chk("R3 native oe", pin_oe[31:0], alt_oe[31:0]);
        check_pins("R3 pins");

        // Random mix over the whole map (R1, R4, R5, R6, R9, R10)
        for (int it = 0; it < 400; it++) begin
            logic [7:0] a;
            int r;
            r = int'($urandom % 14);
            a = (r < 10) ? addr_tab(r) : 8'($urandom);
            bus_write(a, $urandom);
            @(negedge clk);
            pin_in  = NP'({$urandom, $urandom, $urandom});
            alt_out = NP'({$urandom, $urandom, $urandom});
            alt_oe  = NP'({$urandom, $urandom, $urandom});
            repeat (3) @(negedge clk);
            read_chk("R6 random read", addr_tab(int'($urandom % 10)));
            check_pins("R4 random pins");
        end
        check_all("R1 final map");
        finish_run();
    end

endmodule